// File: doc/BRIEF.md
# Real-Time Timer with Alarm

A free-running 32-bit tick counter paced by a slow-clock strobe through a programmable divider. Each time the divider has seen its programmed number of slow-clock strobes, the counter steps by one and an increment flag is raised. When the counter reaches a programmed compare value, an alarm flag is raised. Programming the divider with the slow-clock frequency gives a count in seconds.

Software reaches the block through four 32-bit word registers on a simple select/write bus. Read data comes back registered, one cycle after the read strobe. The counter cannot be loaded. The only way to change it is a restart command, which zeroes it together with the divider. Reading the flag register returns the flags and clears them. An interrupt line combines each flag with its own enable.

Top module: `rtt_core`

## Requirements
- R1: After reset, the register reads return these values: control 0x00008000 (divider 0x8000, both enables off), compare 0xFFFFFFFF (the "no alarm" marker), counter 0 and flags 0. The interrupt output is low.
- R2: The counter increases by exactly one on every N-th slow strobe, where N is control bits 15:0. It never changes by any other amount except a restart to zero.
- R3: Writes to the counter word (offset 0x08) and to the flag word (offset 0x0C) change no state.
- R4: A control write (offset 0x00) with bit 18 set zeroes the counter and the divider in the next cycle. Bit 18 always reads back as 0. Bits 15:0, 16 and 17 take the written values.
- R5: Flag bit 1 is set by every counter step. A read of the flag word (offset 0x0C) returns the flags and then clears them.
- R6: Flag bit 0 is set only on the step where the counter becomes equal to the compare word (offset 0x04). The next step, which moves past the compare value, sets only bit 1.
- R7: The interrupt output is high exactly when flag bit 0 is set with control bit 16 set, or flag bit 1 is set with control bit 17 set. A flag whose enable is off does not raise the interrupt.
- R8: While control bits 15:0 are zero, slow strobes do not advance the counter and raise no flag.
- R9: When a counter step falls in the same cycle as a flag read, the read returns the old flags and the new flag remains set for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle strobe per slow-clock period |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Byte offset of the word register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after the read |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a counter step that lands in the same cycle as a flag read. The stimulus clears the flags, then feeds exactly one strobe fewer than the divider. It then issues the flag read in the same cycle as the final strobe, so the read and the step meet at one clock edge. Alarm matching is driven by a small divider and by counting strobes exactly. This lets the bench predict both the step that hits the compare value and the step that moves past it.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
    localparam int OFF_CTRL  = 0;
    localparam int OFF_CMP   = 4;
    localparam int OFF_COUNT = 8;
    localparam int OFF_FLAGS = 12;

    localparam int BIT_ALM_IE  = 16;
    localparam int BIT_INC_IE  = 17;
    localparam int BIT_RESTART = 18;

    localparam int FLAG_ALM = 0;
    localparam int FLAG_INC = 1;
endpackage

// File: rtl/rtt_divider.sv
module rtt_divider #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_en,
    input  logic          restart,
    input  logic [PW-1:0] reload,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic running, wrap;

    always_comb begin
        st_d    = st_q;
        running = (reload != '0) && slow_en && !restart;
        wrap    = st_q.cnt >= (reload - PW'(1));
        tick    = running && wrap;
        if (restart) begin
            st_d.cnt = '0;
        end else if (running) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
    parameter int VW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic [VW-1:0] cmp,
    output logic [VW-1:0] value,
    output logic          hit
);
    typedef struct packed {
        logic [VW-1:0] value;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [VW-1:0] plus_one;

    always_comb begin
        st_d     = st_q;
        plus_one = st_q.value + VW'(1);
        hit      = tick && (plus_one == cmp);
        if (restart)   st_d.value = '0;
        else if (tick) st_d.value = plus_one;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.value;
endmodule

// File: rtl/rtt_flags.sv
module rtt_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_alm,
    input  logic       set_inc,
    input  logic       clr,
    output logic [1:0] flags
);
    typedef struct packed {
        logic inc;
        logic alm;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d = clr ? '0 : st_q;
        if (set_alm) st_d.alm = 1'b1;
        if (set_inc) st_d.inc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = {st_q.inc, st_q.alm};
endmodule

// File: rtl/rtt_core.sv
module rtt_core #(
    parameter int AW         = 4,
    parameter int DW         = 32,
    parameter int PW         = 16,
    parameter int DIV_RESET  = 16'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_en,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    import rtt_pkg::*;

    localparam int PAD_W = DW - PW - 2;

    typedef struct packed {
        logic [PW-1:0] reload;
        logic          alm_ie;
        logic          inc_ie;
        logic [DW-1:0] cmp;
        logic [DW-1:0] rdata;
    } reg_t;

    reg_t st_d, st_q;

    logic          wr_ctrl, wr_cmp, rd_any, rd_flags, restart;
    logic          tick, hit;
    logic [DW-1:0] value;
    logic [1:0]    flags;

    rtt_divider #(.PW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
        .restart(restart), .reload(st_q.reload), .tick(tick)
    );

    rtt_counter #(.VW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .cmp(st_q.cmp), .value(value), .hit(hit)
    );

    rtt_flags u_flg (
        .clk(clk), .rst_n(rst_n), .set_alm(hit), .set_inc(tick),
        .clr(rd_flags), .flags(flags)
    );

    always_comb begin
        wr_ctrl  = bus_sel && bus_wr && (bus_addr == AW'(OFF_CTRL));
        wr_cmp   = bus_sel && bus_wr && (bus_addr == AW'(OFF_CMP));
        rd_any   = bus_sel && !bus_wr;
        rd_flags = rd_any && (bus_addr == AW'(OFF_FLAGS));
        restart  = wr_ctrl && bus_wdata[BIT_RESTART];

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.reload = bus_wdata[PW-1:0];
            st_d.alm_ie = bus_wdata[BIT_ALM_IE];
            st_d.inc_ie = bus_wdata[BIT_INC_IE];
        end
        if (wr_cmp) st_d.cmp = bus_wdata;

        if (rd_any) begin
            case (bus_addr)
                AW'(OFF_CTRL):  st_d.rdata = {{PAD_W{1'b0}}, st_q.inc_ie, st_q.alm_ie, st_q.reload};
                AW'(OFF_CMP):   st_d.rdata = st_q.cmp;
                AW'(OFF_COUNT): st_d.rdata = value;
                AW'(OFF_FLAGS): st_d.rdata = {{(DW-2){1'b0}}, flags};
                default:        st_d.rdata = '0;
            endcase
        end

        irq = (flags[FLAG_ALM] && st_q.alm_ie) || (flags[FLAG_INC] && st_q.inc_ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.reload <= PW'(DIV_RESET);
            st_q.alm_ie <= 1'b0;
            st_q.inc_ie <= 1'b0;
            st_q.cmp    <= '1;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          irq,
    input logic [DW-1:0] value,
    input logic [DW-1:0] cmp,
    input logic [1:0]    flags,
    input logic          tick,
    input logic [PW-1:0] reload
);
    logic wr_ctrl, rd_ctrl, rd_flags;
    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == AW'(0));
    assign rd_ctrl  = bus_sel && !bus_wr && (bus_addr == AW'(0));
    assign rd_flags = bus_sel && !bus_wr && (bus_addr == AW'(12));

    // R4: restart zeroes the counter
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[18]) |=> (value == '0));

    // R4: restart bit never reads back set
    assert_restart_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> !bus_rdata[18]);

    // R2: counter moves by one or restarts
    assert_value_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl && bus_wdata[18]) |=> (value == $past(value) || value == $past(value) + DW'(1)));

    // R8: zero divider holds counter
    assert_hold_zero_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0 && !wr_ctrl) |=> $stable(value));

    // R6: alarm flag rises only on a match
    assert_alarm_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> (value == cmp));

    // R5: read clears flags when no step coincides
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !tick) |=> (flags == 2'b00));

    // R9: step during read leaves increment flag set
    assert_step_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && tick) |=> flags[1]);

    // R7: no interrupt without a flag
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00) |-> !irq);
endmodule

bind rtt_core rtt_checker #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .value(value), .cmp(st_q.cmp), .flags(flags),
    .tick(tick), .reload(st_q.reload)
);

// File: tb/sim_rtt_core.sv
module sim_rtt_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtt_core u0 (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data the cycle after a read
    always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] exp,
                            input string tag, input logic with_strobe);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; slow_en = with_strobe;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0; slow_en = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_en = 1'b1;
            @(negedge clk); slow_en = 1'b0;
        end
    endtask

    task automatic check_irq(input string tag, input logic exp);
        @(negedge clk);
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_irq("R1 irq", 1'b0);
        bus_read(4'h0, 32'h0000_8000, "R1 ctrl", 1'b0);
        bus_read(4'h4, 32'hFFFF_FFFF, "R1 cmp", 1'b0);
        bus_read(4'h8, 32'h0, "R1 count", 1'b0);
        bus_read(4'hC, 32'h0, "R1 flags", 1'b0);

        // R2 divide by 3: 8 strobes -> 2 steps
        bus_write(4'h0, 32'h0004_0003);
        strobes(8);
        bus_read(4'h8, 32'd2, "R2 count", 1'b0);
        bus_read(4'hC, 32'h2, "R5 inc flag", 1'b0);
        bus_read(4'hC, 32'h0, "R5 cleared", 1'b0);

        // R3 writes to counter and flags ignored
        bus_write(4'h8, 32'h0000_1234);
        bus_read(4'h8, 32'd2, "R3 count", 1'b0);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'hC, 32'h0, "R3 flags", 1'b0);

        // R4 restart, alarm enable on
        bus_write(4'h0, 32'h0005_0003);
        bus_read(4'h0, 32'h0001_0003, "R4 ctrl", 1'b0);
        bus_read(4'h8, 32'd0, "R4 count", 1'b0);

        // R6/R7 alarm at 2
        bus_write(4'h4, 32'd2);
        bus_read(4'h4, 32'd2, "R6 cmp", 1'b0);
        strobes(3);
        check_irq("R7 masked inc", 1'b0);
        bus_read(4'hC, 32'h2, "R6 step1 inc only", 1'b0);
        strobes(3);
        check_irq("R7 alarm irq", 1'b1);
        bus_read(4'hC, 32'h3, "R6 match", 1'b0);
        check_irq("R7 irq cleared", 1'b0);
        strobes(3);
        bus_read(4'hC, 32'h2, "R6 past match", 1'b0);

        // R9 step coincides with flag read
        bus_write(4'h0, 32'h0003_0003);
        strobes(2);
        bus_read(4'hC, 32'h0, "R9 old flags", 1'b1);
        check_irq("R9 inc irq", 1'b1);
        bus_read(4'hC, 32'h2, "R9 kept", 1'b0);
        bus_read(4'h8, 32'd4, "R9 count", 1'b0);

        // R8 zero divider stops counting
        bus_write(4'h0, 32'h0003_0000);
        strobes(5);
        bus_read(4'h8, 32'd4, "R8 count", 1'b0);
        bus_read(4'hC, 32'h0, "R8 flags", 1'b0);
        check_irq("R8 irq", 1'b0);

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule